// File: doc/BRIEF.md
# Quarter-Page Protected Data Translation Buffer

This block is a small, fully associative translation buffer for data accesses. Each slot maps a 4-Kbyte virtual page to a physical page. A 4-bit quarter mask in the slot states which 1-Kbyte quarters of that page the slot answers for. One slot can therefore cover a whole page. Several slots with disjoint masks can instead split one page into halves or quarters, each with its own physical page and attributes.

Software fills slots through a single-cycle load port and can drop every slot at once with a global invalidate. Each access presents an effective address, a valid strobe and a write flag. One cycle later the block returns exactly one outcome: a hit with the translated address and the cache-inhibit, write-through and guarded bits; a miss; or a protection error. A clear change bit in a slot acts as write protection. A write that lands on such a slot reports the error and evicts that slot. No reference tracking is kept.

Top module: `quarter_tlb`

## Requirements
- R1: A request hits a slot only when the slot is valid, its tag equals address bits [31:12], and the mask bit picked by address bits [11:10] is set. Mask bit 3 covers quarter 0 (bits [11:10] = 00) and mask bit 0 covers quarter 3 (bits [11:10] = 11).
- R2: On a hit, `rsp_paddr` is the slot's physical page number followed by address bits [11:0], and `rsp_ci`, `rsp_wt`, `rsp_grd` are the slot's bits. When there is no hit, the address and attribute outputs are zero.
- R3: `rsp_miss` is raised when no slot qualifies, including when the tag matches but the quarter's mask bit is clear. At most one of hit, miss and error is high.
- R4: When several slots qualify, the slot with the lowest index supplies the result.
- R5: A write whose winning slot has a change bit of 0 raises `rsp_prot_err` for one cycle with hit and miss low, and clears that slot's valid bit. Later accesses to it miss, and other slots are untouched.
- R6: Outcomes are registered and appear in the cycle after the request. In the cycle after a cycle with `req_vld` low, hit, miss and error are all low.
- R7: A load with `ld_en` high writes slot `ld_idx` and marks it valid at the next edge. A request made in the same cycle as the load still sees the old slot contents.
- R8: `inv_all` clears every valid bit at the next edge and overrides a load made in the same cycle.
- R9: Reads never raise a protection error and never change a slot, whatever its change bit. Repeated reads return the same result.
- R10: After reset, all outcome outputs are zero and every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write a slot this cycle |
| ld_idx | input | 3 | Slot index to write |
| ld_tag | input | 20 | Virtual page number for the slot |
| ld_ppn | input | 20 | Physical page number for the slot |
| ld_mask | input | 4 | Quarter mask; bit 3 covers the lowest quarter |
| ld_chg | input | 1 | Change bit; 0 makes the slot write-protected |
| ld_ci | input | 1 | Cache-inhibit attribute |
| ld_wt | input | 1 | Write-through attribute |
| ld_grd | input | 1 | Guarded attribute |
| inv_all | input | 1 | Clear every valid bit |
| req_vld | input | 1 | Access request |
| req_addr | input | 32 | Effective address |
| req_wr | input | 1 | Access is a write |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot qualified |
| rsp_prot_err | output | 1 | Write to a write-protected slot |
| rsp_paddr | output | 32 | Translated address |
| rsp_ci | output | 1 | Cache-inhibit of the winning slot |
| rsp_wt | output | 1 | Write-through of the winning slot |
| rsp_grd | output | 1 | Guarded bit of the winning slot |

## Verification
Every outcome is due exactly one edge after its request. The bench drives a request on a falling edge, lets one rising edge capture it, and reads the outputs on the next falling edge. Slot contents loaded or evicted at an edge are first visible to a request driven after that edge. So eviction and load checks issue their follow-up lookup one cycle later. Same-cycle load, invalidate and request cases are driven together in a single cycle to pin down which contents the result uses.

// File: rtl/qtlb_pkg.sv
package qtlb_pkg;
   typedef struct packed {
      logic ci;
      logic wt;
      logic grd;
   } qtlb_attr_t;
endpackage

// File: rtl/qtlb_entry.sv
module qtlb_entry
   import qtlb_pkg::*;
#(
   parameter int TAG_W = 20,
   parameter int PPN_W = 20,
   parameter int SUB_N = 4,
   localparam int SUB_W = $clog2(SUB_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic             ld_we,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic [PPN_W-1:0] ld_ppn,
   input  logic [SUB_N-1:0] ld_mask,
   input  logic             ld_chg,
   input  qtlb_attr_t       ld_attr,
   input  logic             kill,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [SUB_W-1:0] lk_sub,
   output logic             match,
   output logic [PPN_W-1:0] ppn,
   output logic             chg,
   output qtlb_attr_t       attr
);
   localparam logic [SUB_W-1:0] TOP_SUB = SUB_W'(SUB_N - 1);

   logic             valid_q;
   logic [TAG_W-1:0] tag_q;
   logic [SUB_N-1:0] mask_q;

   // invalidate beats load, load beats eviction
   always_ff @(posedge clk) begin
      if (!rst_n)       valid_q <= 1'b0;
      else if (inv_all) valid_q <= 1'b0;
      else if (ld_we)   valid_q <= 1'b1;
      else if (kill)    valid_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         ppn    <= '0;
         mask_q <= '0;
         chg    <= 1'b0;
         attr   <= '0;
      end else if (ld_we) begin
         tag_q  <= ld_tag;
         ppn    <= ld_ppn;
         mask_q <= ld_mask;
         chg    <= ld_chg;
         attr   <= ld_attr;
      end
   end

   // highest mask bit answers for the lowest quarter
   assign match = valid_q && (tag_q == lk_tag) && mask_q[TOP_SUB - lk_sub];

   a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> !valid_q);
   a_r5_kill_evicts: assert property (@(posedge clk) disable iff (!rst_n)
      kill && !ld_we && !inv_all |=> !valid_q);
   a_r7_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we && !inv_all |=> valid_q && tag_q == $past(ld_tag));
endmodule

// File: rtl/qtlb_prio.sv
module qtlb_prio #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/quarter_tlb.sv
module quarter_tlb
   import qtlb_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int PADDR_W = 32,
   parameter int OFF_W   = 12,
   parameter int SUB_N   = 4,
   parameter int ENTRIES = 8,
   localparam int TAG_W  = ADDR_W - OFF_W,
   localparam int PPN_W  = PADDR_W - OFF_W,
   localparam int SUB_W  = $clog2(SUB_N),
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [IDX_W-1:0]   ld_idx,
   input  logic [TAG_W-1:0]   ld_tag,
   input  logic [PPN_W-1:0]   ld_ppn,
   input  logic [SUB_N-1:0]   ld_mask,
   input  logic               ld_chg,
   input  logic               ld_ci,
   input  logic               ld_wt,
   input  logic               ld_grd,
   input  logic               inv_all,
   input  logic               req_vld,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_wr,
   output logic               rsp_hit,
   output logic               rsp_miss,
   output logic               rsp_prot_err,
   output logic [PADDR_W-1:0] rsp_paddr,
   output logic               rsp_ci,
   output logic               rsp_wt,
   output logic               rsp_grd
);
   // elaboration-time parameter checks
   if (ENTRIES < 1) begin : g_bad_entries
      $error("quarter_tlb: ENTRIES must be at least 1");
   end
   if (SUB_N < 2 || (1 << SUB_W) != SUB_N) begin : g_bad_sub
      $error("quarter_tlb: SUB_N must be a power of two >= 2");
   end
   if (OFF_W <= SUB_W || OFF_W >= ADDR_W || OFF_W >= PADDR_W) begin : g_bad_off
      $error("quarter_tlb: OFF_W out of range");
   end

   qtlb_attr_t             ld_attr;
   logic [TAG_W-1:0]       lk_tag;
   logic [SUB_W-1:0]       lk_sub;
   logic [ENTRIES-1:0]     e_match, e_chg, e_kill;
   logic [PPN_W-1:0]       e_ppn  [ENTRIES];
   qtlb_attr_t             e_attr [ENTRIES];
   logic [IDX_W-1:0]       sel;
   logic                   any;
   logic                   viol, hit_d;
   logic [PPN_W-1:0]       sel_ppn;
   qtlb_attr_t             sel_attr;

   assign ld_attr = '{ci: ld_ci, wt: ld_wt, grd: ld_grd};
   assign lk_tag  = req_addr[ADDR_W-1:OFF_W];
   assign lk_sub  = req_addr[OFF_W-1 -: SUB_W];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      qtlb_entry #(.TAG_W(TAG_W), .PPN_W(PPN_W), .SUB_N(SUB_N)) u_entry (
         .clk     (clk),
         .rst_n   (rst_n),
         .inv_all (inv_all),
         .ld_we   (ld_en && (ld_idx == IDX_W'(g))),
         .ld_tag  (ld_tag),
         .ld_ppn  (ld_ppn),
         .ld_mask (ld_mask),
         .ld_chg  (ld_chg),
         .ld_attr (ld_attr),
         .kill    (e_kill[g]),
         .lk_tag  (lk_tag),
         .lk_sub  (lk_sub),
         .match   (e_match[g]),
         .ppn     (e_ppn[g]),
         .chg     (e_chg[g]),
         .attr    (e_attr[g])
      );
   end

   qtlb_prio #(.N(ENTRIES)) u_prio (
      .req (req_vld ? e_match : '0),
      .idx (sel),
      .any (any)
   );

   assign sel_ppn  = e_ppn[sel];
   assign sel_attr = e_attr[sel];
   assign viol     = any && req_wr && !e_chg[sel];
   assign hit_d    = any && !viol;

   always_comb begin
      e_kill = '0;
      if (viol) e_kill[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_prot_err <= 1'b0;
         rsp_paddr    <= '0;
         rsp_ci       <= 1'b0;
         rsp_wt       <= 1'b0;
         rsp_grd      <= 1'b0;
      end else begin
         rsp_hit      <= hit_d;
         rsp_miss     <= req_vld && !any;
         rsp_prot_err <= viol;
         rsp_paddr    <= hit_d ? {sel_ppn, req_addr[OFF_W-1:0]} : '0;
         rsp_ci       <= hit_d && sel_attr.ci;
         rsp_wt       <= hit_d && sel_attr.wt;
         rsp_grd      <= hit_d && sel_attr.grd;
      end
   end

   a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_prot_err}));
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !(rsp_hit || rsp_miss || rsp_prot_err));
   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> !rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));
   a_r2_zero_when_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> rsp_paddr == '0 && !rsp_ci && !rsp_wt && !rsp_grd);
   a_r9_read_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !req_wr |=> !rsp_prot_err);
   a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && any |-> e_match[sel] && ((e_match & ((ENTRIES'(1) << sel) - 1'b1)) == '0));
endmodule

// File: tb/quarter_tlb_bench.sv
module quarter_tlb_bench;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic [37:0] exp;   // {hit, miss, err, paddr[31:0], ci, wt, grd}
   } vec_t;

   localparam logic [37:0] MISS = {3'b010, 32'h0, 3'b000};

   localparam vec_t VECS [12] = '{
      '{32'h00010ABC, 1'b0, {3'b100, 32'hAAAAAABC, 3'b100}}, // R1 R4 full mask, quarter 2
      '{32'h00020123, 1'b0, {3'b100, 32'h11111123, 3'b010}}, // R1 quarter 0 -> mask bit 3
      '{32'h00020456, 1'b0, {3'b100, 32'h22222456, 3'b001}}, // R9 read of protected slot
      '{32'h0002089A, 1'b0, {3'b100, 32'h3333389A, 3'b110}}, // R1 quarter 2
      '{32'h00020FFF, 1'b0, {3'b100, 32'h44444FFF, 3'b011}}, // R1 quarter 3 -> mask bit 0
      '{32'h000307FF, 1'b0, {3'b100, 32'h555557FF, 3'b100}}, // R2 lower half slot
      '{32'h00030800, 1'b0, {3'b100, 32'h66666800, 3'b010}}, // R2 quarter 2 slot
      '{32'h00030C00, 1'b0, MISS},                            // R3 tag hit, mask clear
      '{32'h00040000, 1'b0, MISS},                            // R3 no tag
      '{32'h00020C00, 1'b1, {3'b100, 32'h44444C00, 3'b011}}, // R5 write, change set
      '{32'h00010000, 1'b1, {3'b100, 32'hAAAAA000, 3'b100}}, // R5 write, change set
      '{32'h00030000, 1'b1, {3'b100, 32'h55555000, 3'b100}}  // R2 half slot, quarter 0
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_chg = 1'b0, ld_ci = 1'b0, ld_wt = 1'b0, ld_grd = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [19:0] ld_tag = '0, ld_ppn = '0;
   logic [3:0]  ld_mask = '0;
   logic        inv_all = 1'b0, req_vld = 1'b0, req_wr = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_hit, rsp_miss, rsp_prot_err, rsp_ci, rsp_wt, rsp_grd;
   logic [31:0] rsp_paddr;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   quarter_tlb u_quarter_tlb (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag),
      .ld_ppn(ld_ppn), .ld_mask(ld_mask), .ld_chg(ld_chg), .ld_ci(ld_ci),
      .ld_wt(ld_wt), .ld_grd(ld_grd), .inv_all(inv_all), .req_vld(req_vld),
      .req_addr(req_addr), .req_wr(req_wr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_prot_err(rsp_prot_err), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
      .rsp_wt(rsp_wt), .rsp_grd(rsp_grd)
   );

   function automatic logic [37:0] outs();
      return {rsp_hit, rsp_miss, rsp_prot_err, rsp_paddr, rsp_ci, rsp_wt, rsp_grd};
   endfunction

   task automatic chk(input string rq, input logic [37:0] act, input logic [37:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic drive_load(input logic [2:0] idx, input logic [19:0] tag,
                             input logic [19:0] ppn, input logic [3:0] mask,
                             input logic chg, input logic [2:0] attr);
      ld_en = 1'b1; ld_idx = idx; ld_tag = tag; ld_ppn = ppn; ld_mask = mask;
      ld_chg = chg; {ld_ci, ld_wt, ld_grd} = attr;
   endtask

   task automatic load(input logic [2:0] idx, input logic [19:0] tag,
                       input logic [19:0] ppn, input logic [3:0] mask,
                       input logic chg, input logic [2:0] attr);
      @(negedge clk);
      drive_load(idx, tag, ppn, mask, chg, attr);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // request on a falling edge, captured at the next rising edge, read one falling edge later
   task automatic lookup(input string rq, input logic [31:0] addr, input logic wr,
                         input logic [37:0] exp);
      @(negedge clk);
      req_vld = 1'b1; req_addr = addr; req_wr = wr;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
      chk(rq, outs(), exp);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         errors++;
         $display("FAIL R6 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R10 outputs after reset", outs(), '0);
      lookup("R10 empty after reset", 32'h00010ABC, 1'b0, MISS);

      load(3'd0, 20'h00010, 20'hAAAAA, 4'b1111, 1'b1, 3'b100);
      load(3'd1, 20'h00020, 20'h11111, 4'b1000, 1'b1, 3'b010);
      load(3'd2, 20'h00020, 20'h22222, 4'b0100, 1'b0, 3'b001);
      load(3'd3, 20'h00020, 20'h33333, 4'b0010, 1'b1, 3'b110);
      load(3'd4, 20'h00020, 20'h44444, 4'b0001, 1'b1, 3'b011);
      load(3'd5, 20'h00030, 20'h55555, 4'b1100, 1'b1, 3'b100);
      load(3'd6, 20'h00030, 20'h66666, 4'b0010, 1'b1, 3'b010);
      load(3'd7, 20'h00010, 20'h77777, 4'b1111, 1'b1, 3'b111);

      for (int i = 0; i < 12; i++) begin
         lookup($sformatf("R1/R2/R3 vector %0d", i), VECS[i].addr, VECS[i].wr, VECS[i].exp);
      end

      // R6: no request leaves the outcome outputs low
      @(negedge clk);
      chk("R6 idle cycle", outs(), '0);

      // R5: write to protected quarter-1 slot, then it is gone, neighbour intact
      lookup("R5 write to protected slot", 32'h00020400, 1'b1, {3'b001, 32'h0, 3'b000});
      lookup("R5 evicted slot misses", 32'h00020400, 1'b0, MISS);
      lookup("R5 neighbour kept", 32'h00020800, 1'b0, {3'b100, 32'h33333800, 3'b110});

      // R4: drop slot 0's coverage, slot 7 now supplies the result
      load(3'd0, 20'h00010, 20'hAAAAA, 4'b0000, 1'b1, 3'b100);
      lookup("R4 next slot wins", 32'h00010123, 1'b0, {3'b100, 32'h77777123, 3'b111});

      // R7: load and request in the same cycle; request sees the old slot 1
      @(negedge clk);
      drive_load(3'd1, 20'h00060, 20'h12345, 4'b1111, 1'b1, 3'b000);
      req_vld = 1'b1; req_addr = 32'h00060010; req_wr = 1'b0;
      @(negedge clk);
      ld_en = 1'b0; req_vld = 1'b0;
      chk("R7 same-cycle request sees old contents", outs(), MISS);
      lookup("R7 loaded slot visible", 32'h00060010, 1'b0, {3'b100, 32'h12345010, 3'b000});
      lookup("R7 old mapping replaced", 32'h00020000, 1'b0, MISS);

      // R9: reads of a protected slot repeat without error
      load(3'd2, 20'h00080, 20'h0BEEF, 4'b1111, 1'b0, 3'b101);
      lookup("R9 first read", 32'h00080234, 1'b0, {3'b100, 32'h0BEEF234, 3'b101});
      lookup("R9 second read", 32'h00080234, 1'b0, {3'b100, 32'h0BEEF234, 3'b101});

      // R8: invalidate together with a load; invalidate wins
      @(negedge clk);
      drive_load(3'd5, 20'h00070, 20'h0CAFE, 4'b1111, 1'b1, 3'b000);
      inv_all = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; inv_all = 1'b0;
      lookup("R8 load overridden", 32'h00070000, 1'b0, MISS);
      lookup("R8 slot 7 cleared", 32'h00010000, 1'b0, MISS);
      lookup("R8 slot 2 cleared", 32'h00080234, 1'b0, MISS);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule